// File: doc/BRIEF.md
# Pointer-Located Descriptor DMA Channel

This block is one DMA channel serving one peripheral. Each request moves a single byte between the peripheral's data register and either a register-file location or a location in 16-bit-addressed memory. The channel holds no transfer address or remaining count of its own between requests. Both values sit in ordinary register-file locations, and two pointer inputs owned by the peripheral say where they are. On every request the channel reads this descriptor and moves the byte. It then writes back an address that has gone up by one and a count that has gone down by one. When the count reaches zero it raises a sticky end-of-block flag.

The lowest bit of the counter pointer selects the mode. When it is 1, the descriptor is two bytes in the register file and the data location is also in the register file. When it is 0, the descriptor is two big-endian byte pairs and the data goes to or from memory. A direction input gives the way the byte travels. Requests are taken one at a time, and the channel pulses an acknowledge when the write-back is done.

Top module: `ptr_dma_channel`

## Requirements
- R1: With `cnt_ptr[0]`=1 (register-file mode), the address byte is at `cnt_ptr` with bit 0 cleared and the counter byte is at that location plus 1. `adr_ptr` is not used, and the data byte moves to or from register-file location `address`.
- R2: With `cnt_ptr[0]`=0 (memory mode), the counter pair is at `cnt_ptr` with bit 0 cleared and the address pair is at `adr_ptr` with bit 0 cleared. Each pair has its high byte at the even location and its low byte at the odd location. The data byte moves to or from memory at the 16-bit address.
- R3: With `dir`=1 the byte on `per_rdata` is written to the data location. With `dir`=0 the byte at the data location is driven on `per_wdata` while `per_we` is high for one cycle.
- R4: The address is written back plus one. It wraps from 0xFF to 0x00 in register-file mode and from 0xFFFF to 0x0000 in memory mode.
- R5: The counter is written back minus one.
- R6: `ack` is high for exactly one cycle. It rises 6 clock edges after the edge that accepts `req` in register-file mode, and 10 edges after it in memory mode.
- R7: A request whose counter reads zero moves no data, writes nothing back and gives no `ack`. `eob` keeps its value.
- R8: `eob` is set when the written-back counter is zero. It then stays high until `eob_clr` is pulsed.
- R9: After reset `ack`, `eob` and all write strobes are low.
- R10: `req` is only sampled while the channel is idle. A request held high during a transfer causes no second transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Peripheral transfer request |
| dir | input | 1 | 1: peripheral to location, 0: location to peripheral |
| cnt_ptr | input | 8 | Counter pointer; bit 0 selects register-file mode |
| adr_ptr | input | 8 | Address pair pointer (memory mode) |
| eob_clr | input | 1 | Clears the end-of-block flag |
| ack | output | 1 | One-cycle transfer-done pulse |
| eob | output | 1 | Sticky end-of-block flag |
| rf_addr | output | 8 | Register-file address |
| rf_we | output | 1 | Register-file write strobe |
| rf_wdata | output | 8 | Register-file write data |
| rf_rdata | input | 8 | Register-file read data, same cycle as `rf_addr` |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, same cycle as `mem_addr` |
| per_rdata | input | 8 | Peripheral data register value |
| per_we | output | 1 | Load strobe for the peripheral data register |
| per_wdata | output | 8 | Byte for the peripheral data register |

## Verification
Register-file results and `ack` are due on fixed edges: `ack` after 6 edges in register-file mode and after 10 in memory mode, counted from the accepting edge. The bench counts edges from that accepting edge and samples `ack` on falling edges, so a wrong latency is reported as a count. The stored descriptor, the data bytes and `eob` are checked only after `ack` has been seen. For a zero-count request the bench waits 20 cycles and confirms that no `ack` arrives and that nothing changed.

// File: rtl/ptr_dma_channel.sv
module ptr_dma_channel (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        dir,
  input  logic [7:0]  cnt_ptr,
  input  logic [7:0]  adr_ptr,
  input  logic        eob_clr,
  output logic        ack,
  output logic        eob,
  output logic [7:0]  rf_addr,
  output logic        rf_we,
  output logic [7:0]  rf_wdata,
  input  logic [7:0]  rf_rdata,
  output logic [15:0] mem_addr,
  output logic        mem_we,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  input  logic [7:0]  per_rdata,
  output logic        per_we,
  output logic [7:0]  per_wdata
);
  typedef enum logic [2:0] {S_IDLE, S_RD, S_CHK, S_MOVE, S_WB, S_ACK} st_t;
  st_t state;
  logic [1:0]  stp;
  logic        rm, dr;
  logic [7:0]  cb, ab;
  logic [15:0] cnt, adr;

  wire         last  = rm ? (stp == 2'd1) : (stp == 2'd3);
  wire  [15:0] nc    = cnt - 16'd1;
  wire  [15:0] na    = rm ? {8'h00, adr[7:0] + 8'd1} : adr + 16'd1;
  wire  [7:0]  daddr = (rm ? cb : (stp[1] ? ab : cb)) | {7'd0, stp[0]};
  wire         mv    = (state == S_MOVE);

  always_comb begin
    rf_wdata = per_rdata;
    if (state == S_WB) begin
      if (rm) rf_wdata = stp[0] ? nc[7:0] : na[7:0];
      else case (stp)
        2'd0:    rf_wdata = nc[15:8];
        2'd1:    rf_wdata = nc[7:0];
        2'd2:    rf_wdata = na[15:8];
        default: rf_wdata = na[7:0];
      endcase
    end
  end

  assign rf_addr   = (mv && rm) ? adr[7:0] : daddr;
  assign rf_we     = (state == S_WB) || (mv && rm && dr);
  assign mem_addr  = adr;
  assign mem_we    = mv && !rm && dr;
  assign mem_wdata = per_rdata;
  assign per_we    = mv && !dr;
  assign per_wdata = rm ? rf_rdata : mem_rdata;
  assign ack       = (state == S_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      stp   <= 2'd0;
      rm    <= 1'b0;
      dr    <= 1'b0;
      cb    <= 8'h00;
      ab    <= 8'h00;
      cnt   <= 16'h0000;
      adr   <= 16'h0000;
      eob   <= 1'b0;
    end else begin
      if (eob_clr) eob <= 1'b0;
      case (state)
        S_IDLE: if (req) begin
          rm    <= cnt_ptr[0];
          dr    <= dir;
          cb    <= {cnt_ptr[7:1], 1'b0};
          ab    <= {adr_ptr[7:1], 1'b0};
          stp   <= 2'd0;
          state <= S_RD;
        end
        S_RD: begin
          if (rm) begin
            if (stp[0]) cnt <= {8'h00, rf_rdata};
            else        adr <= {8'h00, rf_rdata};
          end else case (stp)
            2'd0:    cnt[15:8] <= rf_rdata;
            2'd1:    cnt[7:0]  <= rf_rdata;
            2'd2:    adr[15:8] <= rf_rdata;
            default: adr[7:0]  <= rf_rdata;
          endcase
          stp <= stp + 2'd1;
          if (last) state <= S_CHK;
        end
        S_CHK: state <= (cnt == 16'h0000) ? S_IDLE : S_MOVE;
        S_MOVE: begin
          stp   <= 2'd0;
          state <= S_WB;
        end
        S_WB: begin
          stp <= stp + 2'd1;
          if (last) begin
            state <= S_ACK;
            if (nc == 16'h0000) eob <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack);
  p_eob_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n) (eob && !eob_clr) |=> eob);
  p_eob_from_wb_r8: assert property (@(posedge clk) disable iff (!rst_n) $rose(eob) |-> ack);
  p_move_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n) mv |-> (cnt != 16'h0000));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !(rf_we || mem_we || per_we));
  p_one_target_r3: assert property (@(posedge clk) disable iff (!rst_n) !(rf_we && mem_we));
endmodule

// File: tb/ptr_dma_channel_test.sv
module ptr_dma_channel_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, dir = 1'b0, eob_clr = 1'b0;
  logic [7:0] cnt_ptr = 8'h00, adr_ptr = 8'h00, per_rdata = 8'h00;
  logic ack, eob, rf_we, mem_we, per_we;
  logic [7:0] rf_addr, rf_wdata, mem_wdata, per_wdata;
  logic [15:0] mem_addr;
  logic [7:0] rf [256];
  logic [7:0] mem [256];
  logic [7:0] per_got;
  logic [15:0] last_maddr;
  int errors = 0, checks = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_dma_channel uut (
    .clk(clk), .rst_n(rst_n), .req(req), .dir(dir), .cnt_ptr(cnt_ptr),
    .adr_ptr(adr_ptr), .eob_clr(eob_clr), .ack(ack), .eob(eob),
    .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf[rf_addr]),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem[mem_addr[7:0]]), .per_rdata(per_rdata), .per_we(per_we),
    .per_wdata(per_wdata));

  always @(posedge clk) begin
    if (rf_we) rf[rf_addr] <= rf_wdata;
    if (mem_we) begin mem[mem_addr[7:0]] <= mem_wdata; last_maddr <= mem_addr; end
    if (per_we) begin per_got <= per_wdata; last_maddr <= mem_addr; end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      errors = errors + 1; checks = checks + 1;
      $display("FAIL watchdog: run did not end (actual %0d cycles, expected < 5000)", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic go(input bit hold, output int lat);
    @(negedge clk); req = 1'b1;
    @(posedge clk);
    if (!hold) #1 req = 1'b0;
    lat = 0;
    for (int n = 1; n <= 20; n++) begin
      @(posedge clk); @(negedge clk);
      if (ack) begin lat = n; break; end
    end
    req = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(ack == 1'b0, "R9 ack after reset", ack, 0);
    chk(eob == 1'b0, "R9 eob after reset", eob, 0);
    chk(!(rf_we || mem_we || per_we), "R9 strobes after reset", {rf_we, mem_we, per_we}, 0);
  endtask

  task automatic t_rf_in;
    int lat;
    cnt_ptr = 8'h21; adr_ptr = 8'h80; dir = 1'b1; per_rdata = 8'hA5;
    rf[8'h20] = 8'h40; rf[8'h21] = 8'h03; rf[8'h80] = 8'h11; rf[8'h81] = 8'h22;
    go(1'b0, lat);
    chk(lat == 6, "R6 ack latency rf mode", lat, 6);
    chk(rf[8'h40] == 8'hA5, "R3 rf write from peripheral", rf[8'h40], 8'hA5);
    chk(rf[8'h20] == 8'h41, "R4 rf address increment", rf[8'h20], 8'h41);
    chk(rf[8'h21] == 8'h02, "R5 rf counter decrement", rf[8'h21], 8'h02);
    chk(rf[8'h80] == 8'h11 && rf[8'h81] == 8'h22, "R1 adr_ptr unused in rf mode", rf[8'h80], 8'h11);
    chk(eob == 1'b0, "R8 eob low with count left", eob, 0);
  endtask

  task automatic t_rf_out;
    int lat;
    cnt_ptr = 8'h21; dir = 1'b0;
    rf[8'h20] = 8'hFF; rf[8'h21] = 8'h01; rf[8'hFF] = 8'h3C;
    go(1'b0, lat);
    chk(per_got == 8'h3C, "R3 rf read to peripheral", per_got, 8'h3C);
    chk(rf[8'h20] == 8'h00, "R4 rf address wraps", rf[8'h20], 8'h00);
    chk(rf[8'h21] == 8'h00, "R5 rf counter to zero", rf[8'h21], 8'h00);
    chk(eob == 1'b1, "R8 eob set at zero", eob, 1);
  endtask

  task automatic t_zero;
    int lat;
    rf[8'hFF] = 8'h99; rf[8'h00] = 8'h77; per_got = 8'h00; dir = 1'b1;
    go(1'b0, lat);
    chk(lat == 0, "R7 no ack on zero count", lat, 0);
    chk(rf[8'h20] == 8'h00 && rf[8'h21] == 8'h00, "R7 descriptor unchanged", rf[8'h20], 8'h00);
    chk(rf[8'h00] == 8'h77, "R7 no data moved", rf[8'h00], 8'h77);
    chk(eob == 1'b1, "R7 eob kept", eob, 1);
    repeat (3) @(negedge clk);
    chk(eob == 1'b1, "R8 eob sticky", eob, 1);
    eob_clr = 1'b1; @(negedge clk); eob_clr = 1'b0;
    chk(eob == 1'b0, "R8 eob cleared", eob, 0);
  endtask

  task automatic t_mem_in;
    int lat;
    cnt_ptr = 8'h30; adr_ptr = 8'h35; dir = 1'b1; per_rdata = 8'h5A;
    rf[8'h30] = 8'h01; rf[8'h31] = 8'h00; rf[8'h34] = 8'h12; rf[8'h35] = 8'hFF;
    go(1'b0, lat);
    chk(lat == 10, "R6 ack latency mem mode", lat, 10);
    chk(last_maddr == 16'h12FF, "R2 memory address from pair", last_maddr, 16'h12FF);
    chk(mem[8'hFF] == 8'h5A, "R3 mem write from peripheral", mem[8'hFF], 8'h5A);
    chk({rf[8'h34], rf[8'h35]} == 16'h1300, "R4 mem address increment", {rf[8'h34], rf[8'h35]}, 16'h1300);
    chk({rf[8'h30], rf[8'h31]} == 16'h00FF, "R5 mem counter borrow", {rf[8'h30], rf[8'h31]}, 16'h00FF);
    chk(eob == 1'b0, "R8 eob low mem", eob, 0);
  endtask

  task automatic t_mem_out;
    int lat;
    dir = 1'b0;
    rf[8'h30] = 8'h00; rf[8'h31] = 8'h01; rf[8'h34] = 8'hFF; rf[8'h35] = 8'hFF; mem[8'hFF] = 8'h77;
    go(1'b0, lat);
    chk(per_got == 8'h77, "R3 mem read to peripheral", per_got, 8'h77);
    chk(last_maddr == 16'hFFFF, "R2 memory read address", last_maddr, 16'hFFFF);
    chk({rf[8'h34], rf[8'h35]} == 16'h0000, "R4 mem address wraps", {rf[8'h34], rf[8'h35]}, 0);
    chk(eob == 1'b1, "R8 eob set mem", eob, 1);
    eob_clr = 1'b1; @(negedge clk); eob_clr = 1'b0;
  endtask

  task automatic t_busy;
    int lat;
    cnt_ptr = 8'h21; dir = 1'b1; per_rdata = 8'h01;
    rf[8'h20] = 8'h50; rf[8'h21] = 8'h05;
    go(1'b1, lat);
    repeat (10) @(negedge clk);
    chk(rf[8'h21] == 8'h04, "R10 held req gives one transfer", rf[8'h21], 8'h04);
    chk(rf[8'h20] == 8'h51, "R10 address moved once", rf[8'h20], 8'h51);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin rf[i] = 8'h00; mem[i] = 8'h00; end
    per_got = 8'h00; last_maddr = 16'h0000;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_rf_in();
    t_rf_out();
    t_zero();
    t_mem_in();
    t_mem_out();
    t_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule